// File: doc/BRIEF.md
# Processor Write Bus to Quad 12-Bit DAC Register Adapter

This block sits between a synchronous processor write bus and a bank of four 12-bit converter input registers. Each register loads while its active-low select is low. The adapter compares the upper address bits with a fixed base. It turns the low address bits into four select lines, and it drives the 12-bit data word that the selected registers load. A parameter picks how the low address bits are read. In decoded mode a two-bit field names exactly one channel. In per-bit mode each channel has its own address bit, so a single access can load several channels at once.

A parameter also sets the bus width. With a bus of 16 bits or more, one write carries a whole word. A run-time input then picks whether the 12 bits come from the top of the bus word (a binary fraction of full scale) or from the bottom (an integer). With an 8-bit bus, two writes are needed. The first write is held in a byte register. The second write to the same channel address completes a right-justified word, and only that second write produces a select.

Every select pulse lasts a programmed number of clock cycles. This meets the minimum pulse width of the registers. While no channel is selected, the data lines rest at all ones.

Top module: `dac_bus_adapter`

## Requirements
- R1: A select goes low only in the cycle after a clock edge that sampled `bus_wr` high with `bus_addr` above the low field equal to the same bits of `BASE_ADDR`. A write with any other base produces no select.
- R2: In decoded mode, the low two address bits hold a value n from 0 to 3. An accepted write drives `dac_cs_n[n]` low and keeps the other three selects high.
- R3: In per-bit mode, address bit i (for i from 0 to 3) set to 1 selects channel i, so several channels can load from one write. A write whose four low address bits are all 0 selects nothing.
- R4: On a 16-bit bus with `justify_left` = 0, the output word is `bus_data[11:0]`.
- R5: On a 16-bit bus with `justify_left` = 1, the output word is `bus_data[15:4]`.
- R6: On an 8-bit bus, the first write to a channel address produces no select and is held. The next write to the same channel address selects that channel. Its output word is {second byte bits 3:0, first byte}, and bits 7:4 of the second byte are ignored.
- R7: On an 8-bit bus, suppose a byte is held and a write arrives to a different channel address. The held byte is discarded, and this write becomes the new first byte.
- R8: Each select stays low for exactly `MIN_PULSE` consecutive cycles. The output word stays unchanged for that whole time.
- R9: After reset, and whenever no select is low, all selects are high and `dac_data` is all ones.
- R10: A bus write sampled while a select pulse is active is dropped. It does not change that pulse, and it does not produce a later one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | ADDR_W | Write address: base field above the channel field |
| bus_data | input | BUS_W | Write data |
| justify_left | input | 1 | Picks the word from the top of the bus (1) or the bottom (0); has no effect on an 8-bit bus |
| dac_cs_n | output | NCH | Active-low register selects, one per channel |
| dac_data | output | 12 | Word for the selected registers; all ones when idle |

## Verification
The bench builds two copies, both with `MIN_PULSE` = 3 and an 8-bit address. The first uses a 16-bit bus with decoded selects and base 0x54. It covers both justifications, every channel, and writes that arrive during a pulse. The second uses an 8-bit bus with per-bit selects and base 0xA0. It covers the two-write assembly, the restart when the channel address changes, the empty channel mask and a write to all four channels at once. Random writes, some with a wrong base, run on both copies and are compared against a model in the bench.

// File: rtl/dab_pkg.sv
package dab_pkg;
  localparam int DAC_W = 12;

  typedef enum logic {
    SEL_DECODED = 1'b0,
    SEL_PER_BIT = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/dab_addr_decode.sv
module dab_addr_decode #(
  parameter int ADDR_W = 8,
  parameter int NCH = 4,
  parameter int LOW_W = 2,
  parameter dab_pkg::sel_mode_e SEL_MODE = dab_pkg::SEL_DECODED,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              hit,
  output logic [NCH-1:0]    mask,
  output logic [LOW_W-1:0]  key
);
  logic base_ok;

  assign key     = bus_addr[LOW_W-1:0];
  assign base_ok = (bus_addr[ADDR_W-1:LOW_W] == BASE_ADDR[ADDR_W-1:LOW_W]);

  generate
    if (SEL_MODE == dab_pkg::SEL_DECODED) begin : g_dec
      for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign mask[i] = (key == LOW_W'(i));
      end
      // R2: a decoded access never names more than one channel
      assert_single_channel_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mask));
    end else begin : g_bit
      assign mask = key[NCH-1:0];
    end
  endgenerate

  assign hit = bus_wr && base_ok && (|mask);
endmodule

// File: rtl/dab_word_build.sv
module dab_word_build #(
  parameter int BUS_W = 16,
  parameter int DAC_W = 12,
  parameter int LOW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [LOW_W-1:0] key,
  input  logic [BUS_W-1:0] data,
  input  logic             justify_left,
  output logic             fire,
  output logic [DAC_W-1:0] word
);
  generate
    if (BUS_W >= DAC_W) begin : g_wide
      logic unused_wide;
      assign unused_wide = ^{key, clk, rst};
      assign fire = take;
      assign word = justify_left ? data[BUS_W-1 -: DAC_W] : data[DAC_W-1:0];
    end else begin : g_pair
      localparam int HI_W = DAC_W - BUS_W;
      logic [BUS_W-1:0] held_q;
      logic [LOW_W-1:0] key_q;
      logic             valid_q;
      logic             match;
      logic             unused_pair;

      assign unused_pair = ^{justify_left, data[BUS_W-1:HI_W]};
      assign match = valid_q && (key_q == key);
      assign fire  = take && match;
      assign word  = {data[HI_W-1:0], held_q};

      always_ff @(posedge clk) begin
        if (rst) begin
          valid_q <= 1'b0;
          held_q  <= '0;
          key_q   <= '0;
        end else if (take) begin
          if (match) begin
            valid_q <= 1'b0;
          end else begin
            valid_q <= 1'b1;
            held_q  <= data;
            key_q   <= key;
          end
        end
      end

      // R6: a completed pair leaves nothing held
      assert_pair_done_R6: assert property (@(posedge clk) disable iff (rst)
        fire |=> !valid_q);
      // R7: a write to another channel address restarts with its own byte
      assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (take && valid_q && (key != key_q)) |=> (valid_q && key_q == $past(key)
                                                 && held_q == $past(data)));
    end
  endgenerate
endmodule

// File: rtl/dab_pulse_gen.sv
module dab_pulse_gen #(
  parameter int NCH = 4,
  parameter int DAC_W = 12,
  parameter int MIN_PULSE = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [NCH-1:0]   mask,
  input  logic [DAC_W-1:0] word,
  output logic [NCH-1:0]   cs_n,
  output logic [DAC_W-1:0] dac_data,
  output logic             idle
);
  localparam int CW = $clog2(MIN_PULSE + 1);

  logic [NCH-1:0]   cs_n_q;
  logic [DAC_W-1:0] data_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_q <= '1;
      data_q <= '1;
      cnt_q  <= '0;
    end else if (fire) begin
      cs_n_q <= ~mask;
      data_q <= word;
      cnt_q  <= CW'(MIN_PULSE - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      cs_n_q <= '1;
      data_q <= '1;
    end
  end

  assign cs_n     = cs_n_q;
  assign dac_data = data_q;
  assign idle     = &cs_n_q;

  // checker: length of the current low pulse, saturating
  logic [CW-1:0] len_q;
  always_ff @(posedge clk) begin
    if (rst)                         len_q <= '0;
    else if (idle)                   len_q <= '0;
    else if (len_q < CW'(MIN_PULSE)) len_q <= len_q + 1'b1;
  end

  // R8: a pulse ends only after the programmed width
  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(idle) |-> (len_q >= CW'(MIN_PULSE)));
  // R8: the word is held through the pulse
  assert_word_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (!idle && !$past(idle)) |-> $stable(dac_data));
  // R9: the idle bus level is all ones
  assert_idle_level_R9: assert property (@(posedge clk) disable iff (rst)
    idle |-> (&dac_data));
endmodule

// File: rtl/dac_bus_adapter.sv
module dac_bus_adapter #(
  parameter int BUS_W = 16,
  parameter int ADDR_W = 8,
  parameter int NCH = 4,
  parameter dab_pkg::sel_mode_e SEL_MODE = dab_pkg::SEL_DECODED,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h54,
  parameter int MIN_PULSE = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [BUS_W-1:0]          bus_data,
  input  logic                      justify_left,
  output logic [NCH-1:0]            dac_cs_n,
  output logic [dab_pkg::DAC_W-1:0] dac_data
);
  localparam int DAC_W = dab_pkg::DAC_W;
  localparam int LOW_W = (SEL_MODE == dab_pkg::SEL_DECODED) ? $clog2(NCH) : NCH;

  logic             hit, take, fire, idle;
  logic [NCH-1:0]   mask;
  logic [LOW_W-1:0] key;
  logic [DAC_W-1:0] word;

  dab_addr_decode #(
    .ADDR_W(ADDR_W), .NCH(NCH), .LOW_W(LOW_W),
    .SEL_MODE(SEL_MODE), .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .hit(hit), .mask(mask), .key(key)
  );

  assign take = hit && idle;

  dab_word_build #(.BUS_W(BUS_W), .DAC_W(DAC_W), .LOW_W(LOW_W)) u_build (
    .clk(clk), .rst(rst), .take(take), .key(key), .data(bus_data),
    .justify_left(justify_left), .fire(fire), .word(word)
  );

  dab_pulse_gen #(.NCH(NCH), .DAC_W(DAC_W), .MIN_PULSE(MIN_PULSE)) u_pulse (
    .clk(clk), .rst(rst), .fire(fire), .mask(mask), .word(word),
    .cs_n(dac_cs_n), .dac_data(dac_data), .idle(idle)
  );

  // R1: a select starts only right after a sampled bus write
  assert_select_needs_write_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(idle) |-> $past(bus_wr));
  // R10: selects do not move while a pulse runs, whatever the bus does
  assert_busy_ignores_bus_R10: assert property (@(posedge clk) disable iff (rst)
    (!idle && !$past(idle)) |-> $stable(dac_cs_n));
endmodule

// File: tb/test_dac_bus_adapter.sv
`timescale 1ns/1ps
module test_dac_bus_adapter;
  localparam int P = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        a_wr = 1'b0, a_jl = 1'b0;
  logic [7:0]  a_addr = '0;
  logic [15:0] a_data = '0;
  logic [3:0]  a_cs_n;
  logic [11:0] a_dout;

  logic        b_wr = 1'b0;
  logic [7:0]  b_addr = '0;
  logic [7:0]  b_data = '0;
  logic [3:0]  b_cs_n;
  logic [11:0] b_dout;

  dac_bus_adapter #(.BUS_W(16), .ADDR_W(8), .NCH(4),
    .SEL_MODE(dab_pkg::SEL_DECODED), .BASE_ADDR(8'h54), .MIN_PULSE(P)) i_dac_bus_adapter (
    .clk(clk), .rst(rst), .bus_wr(a_wr), .bus_addr(a_addr), .bus_data(a_data),
    .justify_left(a_jl), .dac_cs_n(a_cs_n), .dac_data(a_dout));

  dac_bus_adapter #(.BUS_W(8), .ADDR_W(8), .NCH(4),
    .SEL_MODE(dab_pkg::SEL_PER_BIT), .BASE_ADDR(8'hA0), .MIN_PULSE(P)) i_dac_bus_adapter_b8 (
    .clk(clk), .rst(rst), .bus_wr(b_wr), .bus_addr(b_addr), .bus_data(b_data),
    .justify_left(1'b0), .dac_cs_n(b_cs_n), .dac_data(b_dout));

  int n_tests = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // 16-bit model (R4, R5)
  function automatic logic [11:0] a_word(input logic [15:0] d, input logic jl);
    return jl ? d[15:4] : d[11:0];
  endfunction

  // watch P+1 negedges on one copy; at entry we sit at the first negedge after the write edge
  task automatic watch(input bit on_b, input logic [3:0] m, input logic [11:0] w, input string req);
    logic [3:0] nm;
    nm = ~m;
    for (int c = 0; c < P + 1; c++) begin
      if (c < P && m != 4'h0) begin
        chk(req, on_b ? b_cs_n : a_cs_n, nm);
        chk(req, on_b ? b_dout : a_dout, w);
      end else begin
        chk({req, "/R9"}, on_b ? b_cs_n : a_cs_n, 4'hF);
        chk({req, "/R9"}, on_b ? b_dout : a_dout, 12'hFFF);
      end
      @(negedge clk);
    end
  endtask

  task automatic write_a(input logic [7:0] ad, input logic [15:0] d, input logic jl, input string req);
    logic [3:0] m;
    a_wr = 1'b1; a_addr = ad; a_data = d; a_jl = jl;
    @(negedge clk);
    a_wr = 1'b0;
    m = (ad[7:2] == 6'h15) ? (4'h1 << ad[1:0]) : 4'h0;   // R1, R2
    watch(1'b0, m, a_word(d, jl), req);
  endtask

  // 8-bit model state (R6, R7)
  logic       hv = 1'b0;
  logic [3:0] hkey = '0;
  logic [7:0] hbyte = '0;

  task automatic write_b(input logic [7:0] ad, input logic [7:0] d, input string req);
    logic [3:0]  m;
    logic [11:0] w;
    b_wr = 1'b1; b_addr = ad; b_data = d;
    @(negedge clk);
    b_wr = 1'b0;
    m = 4'h0; w = 12'hFFF;
    if (ad[7:4] == 4'hA && ad[3:0] != 4'h0) begin
      if (hv && hkey == ad[3:0]) begin
        m = ad[3:0]; w = {d[3:0], hbyte}; hv = 1'b0;
      end else begin
        hv = 1'b1; hkey = ad[3:0]; hbyte = d;
      end
    end
    watch(1'b1, m, w, req);
  endtask

  initial begin
    #(5ns * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk("R9 reset", a_cs_n, 4'hF); chk("R9 reset", a_dout, 12'hFFF);
    chk("R9 reset", b_cs_n, 4'hF); chk("R9 reset", b_dout, 12'hFFF);

    // R2: each channel in decoded mode; R4/R5 justification
    for (int ch = 0; ch < 4; ch++) write_a(8'h54 | 8'(ch), 16'hABCD, 1'b0, "R2 R4");
    write_a(8'h56, 16'hABCD, 1'b1, "R5");
    write_a(8'h57, 16'h5FF0, 1'b0, "R4");
    // R1: wrong base ignored
    write_a(8'h58, 16'h1234, 1'b0, "R1");

    // R10: second write arrives during the pulse
    a_wr = 1'b1; a_addr = 8'h54; a_data = 16'h0123; a_jl = 1'b0;
    @(negedge clk);
    a_addr = 8'h57; a_data = 16'h0FED;
    chk("R10", a_cs_n, 4'hE); chk("R10", a_dout, 12'h123);
    @(negedge clk);
    a_wr = 1'b0;
    for (int c = 1; c < P + 3; c++) begin
      if (c < P) begin
        chk("R10 R8", a_cs_n, 4'hE); chk("R10 R8", a_dout, 12'h123);
      end else begin
        chk("R10", a_cs_n, 4'hF); chk("R10", a_dout, 12'hFFF);
      end
      @(negedge clk);
    end

    // R6: byte pair, upper nibble of second byte ignored
    write_b(8'hA2, 8'h5A, "R6 first");
    write_b(8'hA2, 8'hF3, "R6");
    // R7: change of channel address restarts
    write_b(8'hA1, 8'h11, "R7 first");
    write_b(8'hA2, 8'h22, "R7 restart");
    write_b(8'hA2, 8'h07, "R7");
    write_b(8'hA1, 8'h33, "R7 old key");
    // R3: empty mask ignored, held byte kept; all channels at once
    write_b(8'hA0, 8'h44, "R3 empty");
    write_b(8'h51, 8'h44, "R1 base");
    write_b(8'hA1, 8'h0C, "R3");
    write_b(8'hAF, 8'hC3, "R3 first");
    write_b(8'hAF, 8'h0A, "R3 all");

    // random stimulus on both copies
    for (int k = 0; k < 150; k++) begin
      logic [7:0] ad;
      ad = 8'($urandom);
      if (($urandom % 4) != 0) ad[7:2] = 6'h15;
      write_a(ad, 16'($urandom), 1'($urandom), "R2 R4 R5 rand");
    end
    for (int k = 0; k < 150; k++) begin
      logic [7:0] ad;
      ad = {4'hA, hkey};
      if (($urandom % 3) == 0) ad[3:0] = 4'($urandom);
      if (($urandom % 6) == 0) ad[7:4] = 4'($urandom);
      write_b(ad, 8'($urandom), "R6 R7 R3 rand");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule